// File: doc/BRIEF.md
# Bank Write-Recovery and Precharge Timing Guard

This block sits beside one bank of a DDR SDRAM controller and decides, cycle by cycle, whether a requested command to that bank may go out now or must wait. It follows the bank through activate, write, write with auto-precharge and precharge. It keeps three countdowns: row-active time since the activate, write recovery since the last data beat actually taken, and precharge time since the bank was closed. When a precharge or activate would break one of these windows, the request is held with a stall. When it is legal, it is granted in the same cycle.

The write datapath reports, with a one-cycle pulse, the cycle in which the last valid write data was taken. For a full burst this is the nominal end, which is four clocks for eight beats. For a burst cut short by a precharge or replaced by a new write to another column, it is the last unmasked beat. Write recovery is always counted from that pulse.

A write with auto-precharge is handled as a write followed by the earliest precharge that leaves the burst intact. The block starts that precharge itself, flags the start for one cycle, and then holds the next activate for the precharge time.

Top module: `bank_wr_guard`

## Requirements
- R1: After a synchronous reset the bank is closed with every countdown expired, so an activate is granted in the first cycle after reset, and without a request neither grant nor stall is high.
- R2: Command codes are activate=0, write=1, write with auto-precharge=2, precharge=3. Grant and stall respond combinationally in the request cycle, and a request with reqValid or reqBankHit low raises neither.
- R3: A precharge is granted no earlier than tRas cycles after the cycle in which the activate was granted, and is stalled before that.
- R4: A precharge is stalled while a granted write has not yet reported its last beat, and is granted no earlier than tWr cycles after the lastBeat cycle.
- R5: When lastBeat arrives before the nominal burst end (an interrupted burst), write recovery is counted from that earlier lastBeat cycle.
- R6: A write to an open bank is granted during another write's burst, and write recovery then follows the lastBeat of the latest write.
- R7: When both windows apply, the precharge is granted in the later of the two deadlines, and stall stays high in every cycle before it.
- R8: After a write with auto-precharge, autoPreStart is high for exactly one cycle, the one in which an explicit precharge would first have been granted. Until then every request to the bank is stalled.
- R9: An activate is granted no earlier than tRp cycles after the cycle of a precharge grant or of autoPreStart.
- R10: An activate to an open bank and a write to a closed bank are stalled. A precharge to a closed bank is granted and changes nothing, so a following activate is granted at once.
- R11: A timing count of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | A command request is present |
| reqCmd | input | 2 | Command code (see R2) |
| reqBankHit | input | 1 | The request targets this bank |
| lastBeat | input | 1 | Pulse: last valid write data taken this cycle |
| tWr | input | CNT_W | Write-recovery count in clocks |
| tRp | input | CNT_W | Precharge time in clocks |
| tRas | input | CNT_W | Minimum activate-to-precharge time in clocks |
| grant | output | 1 | The request is issued this cycle |
| stall | output | 1 | The request must be held |
| autoPreStart | output | 1 | The internal auto-precharge starts this cycle |

## Verification
The hardest case to reach is the auto-precharge start. The bench must open the row and issue the auto-precharge write, then deliver lastBeat a few cycles later. It must then watch autoPreStart while other requests are being stalled, and only after that the delayed activate. The stimulus therefore drives a fixed cycle-by-cycle script: lastBeat is placed on a chosen cycle, and stall requests are interleaved on the cycles before the expected start, so that a start one cycle early or late shows up. The interrupted-burst and random-column cases are reached the same way, by moving the lastBeat pulse away from the nominal burst end and checking that the precharge grant moves with it.

// File: rtl/bwg_pkg.sv
package bwg_pkg;
  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_WR  = 2'd1,
    CMD_WRA = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;

  typedef struct packed {
    logic loadRas;
    logic loadWr;
    logic loadRp;
  } strobe_t;
endpackage

// File: rtl/timing_countdown.sv
module timing_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] span,
  output logic         done
);
  logic [W-1:0] cnt;
  logic [W-1:0] loadVal;

  // Window ends `span` cycles after the load cycle; zero is treated as one.
  assign loadVal = (span == '0) ? '0 : span - W'(1);
  assign done    = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= loadVal;
    else if (cnt != '0) cnt <= cnt - W'(1);
  end

  // R11
  done_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> $past(load));
endmodule

// File: rtl/bank_timers.sv
module bank_timers import bwg_pkg::*; #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          st,
  input  logic [CNT_W-1:0] tWr,
  input  logic [CNT_W-1:0] tRp,
  input  logic [CNT_W-1:0] tRas,
  output logic             rasDone,
  output logic             wrDone,
  output logic             rpDone
);
  localparam int NUM_T = 3;

  logic [NUM_T-1:0] loads;
  logic [NUM_T-1:0] dones;
  logic [CNT_W-1:0] spans [NUM_T];

  assign loads = {st.loadRp, st.loadWr, st.loadRas};

  always_comb begin
    spans[0] = tRas;
    spans[1] = tWr;
    spans[2] = tRp;
  end

  for (genvar i = 0; i < NUM_T; i++) begin : g_tmr
    timing_countdown #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .load (loads[i]),
      .span (spans[i]),
      .done (dones[i])
    );
  end

  assign rasDone = dones[0];
  assign wrDone  = dones[1];
  assign rpDone  = dones[2];

  // R3
  pre_after_ras_chk: assert property (@(posedge clk) disable iff (rst)
    st.loadRp |-> rasDone);
endmodule

// File: rtl/bank_ctrl.sv
module bank_ctrl import bwg_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic [1:0] reqCmd,
  input  logic       reqBankHit,
  input  logic       lastBeat,
  input  logic       rasDone,
  input  logic       wrDone,
  input  logic       rpDone,
  output logic       grant,
  output logic       stall,
  output logic       autoPreStart,
  output strobe_t    st
);
  cmd_e cmd;
  logic active, wrPending, apPending;
  logic hit, allow, recovered, autoStart;
  logic isAct, isPre, isWr;

  assign cmd       = cmd_e'(reqCmd);
  assign hit       = reqValid & reqBankHit;
  assign recovered = !wrPending && wrDone && rasDone;
  assign autoStart = apPending && recovered;

  always_comb begin
    case (cmd)
      CMD_ACT:         allow = !active && rpDone && !apPending;
      CMD_WR, CMD_WRA: allow = active && !apPending;
      default:         allow = !apPending && (!active || recovered);
    endcase
  end

  assign grant        = hit & allow;
  assign stall        = hit & !allow;
  assign autoPreStart = autoStart;

  assign isAct = grant && (cmd == CMD_ACT);
  assign isPre = grant && (cmd == CMD_PRE);
  assign isWr  = grant && (cmd == CMD_WR || cmd == CMD_WRA);

  assign st.loadRas = isAct;
  assign st.loadWr  = lastBeat;
  assign st.loadRp  = (isPre && active) || autoStart;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      wrPending <= 1'b0;
      apPending <= 1'b0;
    end else begin
      active    <= (active | isAct) & !(isPre | autoStart);
      wrPending <= isWr | (wrPending & !lastBeat);
      apPending <= (isWr && cmd == CMD_WRA) | (apPending & !autoStart);
    end
  end

  // R4
  pre_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
    st.loadRp |-> wrDone);

  // R6
  wr_settle_chk: assert property (@(posedge clk) disable iff (rst)
    (lastBeat && !isWr) |=> !wrPending);

  // R8
  ap_close_chk: assert property (@(posedge clk) disable iff (rst)
    autoPreStart |=> (!apPending && !active));

  // R9
  act_after_rp_chk: assert property (@(posedge clk) disable iff (rst)
    isAct |-> rpDone);
endmodule

// File: rtl/bank_wr_guard.sv
module bank_wr_guard import bwg_pkg::*; #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  input  logic [1:0]       reqCmd,
  input  logic             reqBankHit,
  input  logic             lastBeat,
  input  logic [CNT_W-1:0] tWr,
  input  logic [CNT_W-1:0] tRp,
  input  logic [CNT_W-1:0] tRas,
  output logic             grant,
  output logic             stall,
  output logic             autoPreStart
);
  strobe_t st;
  logic rasDone, wrDone, rpDone;

  bank_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .reqValid     (reqValid),
    .reqCmd       (reqCmd),
    .reqBankHit   (reqBankHit),
    .lastBeat     (lastBeat),
    .rasDone      (rasDone),
    .wrDone       (wrDone),
    .rpDone       (rpDone),
    .grant        (grant),
    .stall        (stall),
    .autoPreStart (autoPreStart),
    .st           (st)
  );

  bank_timers #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .st      (st),
    .tWr     (tWr),
    .tRp     (tRp),
    .tRas    (tRas),
    .rasDone (rasDone),
    .wrDone  (wrDone),
    .rpDone  (rpDone)
  );
endmodule

// File: tb/tb_bank_wr_guard.sv
`timescale 1ns/1ps
module tb_bank_wr_guard;
  localparam logic [1:0] ACT = 2'd0, WR = 2'd1, WRA = 2'd2, PRE = 2'd3;

  logic clk = 1'b0, rst = 1'b1;
  logic reqValid = 1'b0, reqBankHit = 1'b0, lastBeat = 1'b0;
  logic [1:0] reqCmd = 2'd0;
  logic [7:0] tWr = 8'd3, tRp = 8'd2, tRas = 8'd5;
  logic grant, stall, autoPreStart;
  logic g, s, a;
  int nChk = 0, nFail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bank_wr_guard dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqCmd(reqCmd),
    .reqBankHit(reqBankHit), .lastBeat(lastBeat), .tWr(tWr), .tRp(tRp),
    .tRas(tRas), .grant(grant), .stall(stall), .autoPreStart(autoPreStart)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock cycle: drive after the falling edge, sample before the rising edge.
  task automatic cyc(input logic [1:0] c, input logic v, input logic h, input logic lb);
    @(negedge clk);
    reqCmd = c; reqValid = v; reqBankHit = h; lastBeat = lb;
    #1;
    g = grant; s = stall; a = autoPreStart;
  endtask

  task automatic req(input logic [1:0] c, input logic lb);
    cyc(c, 1'b1, 1'b1, lb);
  endtask

  task automatic idle(input logic lb);
    cyc(ACT, 1'b0, 1'b0, lb);
  endtask

  task automatic expGS(input logic eg, input logic es, input string tag);
    check(g == eg && s == es, tag, {g, s}, {eg, es});
  endtask

  task automatic doReset;
    @(negedge clk);
    rst = 1'b1; reqValid = 1'b0; reqBankHit = 1'b0; lastBeat = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_r1;
    doReset;
    idle(1'b0);
    expGS(1'b0, 1'b0, "R1 idle after reset");
    check(a == 1'b0, "R1 no auto start", a, 0);
    req(ACT, 1'b0);
    expGS(1'b1, 1'b0, "R1 activate at once");
  endtask

  task automatic t_r2_r10;
    doReset;
    cyc(PRE, 1'b1, 1'b0, 1'b0);
    expGS(1'b0, 1'b0, "R2 no bank hit");
    cyc(PRE, 1'b0, 1'b1, 1'b0);
    expGS(1'b0, 1'b0, "R2 no valid");
    req(WR, 1'b0);
    expGS(1'b0, 1'b1, "R10 write to closed bank");
    req(PRE, 1'b0);
    expGS(1'b1, 1'b0, "R10 precharge closed bank");
    req(ACT, 1'b0);
    expGS(1'b1, 1'b0, "R10 precharge on closed bank no effect");
    req(ACT, 1'b0);
    expGS(1'b0, 1'b1, "R10 activate open bank");
  endtask

  task automatic t_r3_r9;
    doReset;
    req(ACT, 1'b0);
    for (int k = 1; k <= 5; k++) begin
      req(PRE, 1'b0);
      expGS(k == 5, k != 5, $sformatf("R3 precharge at +%0d", k));
    end
    req(ACT, 1'b0);
    expGS(1'b0, 1'b1, "R9 activate within tRp");
    req(ACT, 1'b0);
    expGS(1'b1, 1'b0, "R9 activate at tRp");
  endtask

  task automatic t_r4;
    doReset;
    req(ACT, 1'b0);
    req(WR, 1'b0);
    expGS(1'b1, 1'b0, "R4 write granted");
    for (int k = 2; k <= 8; k++) begin
      req(PRE, k == 5);
      expGS(k == 8, k != 8, $sformatf("R4 precharge at +%0d", k));
    end
  endtask

  task automatic t_r5;
    doReset;
    req(ACT, 1'b0);
    req(WR, 1'b0);
    for (int k = 2; k <= 6; k++) begin
      req(PRE, k == 3);
      expGS(k == 6, k != 6, $sformatf("R5 cut burst precharge at +%0d", k));
    end
  endtask

  task automatic t_r6;
    doReset;
    req(ACT, 1'b0);
    req(WR, 1'b0);
    idle(1'b0);
    req(WR, 1'b0);
    expGS(1'b1, 1'b0, "R6 second write in burst");
    for (int k = 4; k <= 10; k++) begin
      req(PRE, k == 7);
      expGS(k == 10, k != 10, $sformatf("R6 precharge at +%0d", k));
    end
  endtask

  task automatic t_r7;
    tRas = 8'd8;
    doReset;
    req(ACT, 1'b0);
    req(WR, 1'b0);
    for (int k = 2; k <= 8; k++) begin
      req(PRE, k == 2);
      expGS(k == 8, k != 8, $sformatf("R7 later deadline at +%0d", k));
    end
    tRas = 8'd5;
  endtask

  task automatic t_r8;
    doReset;
    req(ACT, 1'b0);
    req(WRA, 1'b0);
    expGS(1'b1, 1'b0, "R8 auto write granted");
    for (int k = 2; k <= 10; k++) begin
      if (k == 6) begin
        req(WR, 1'b0);
        expGS(1'b0, 1'b1, "R8 write held while auto pending");
      end else if (k == 7) begin
        req(PRE, 1'b0);
        expGS(1'b0, 1'b1, "R8 precharge held while auto pending");
      end else if (k >= 9) begin
        req(ACT, 1'b0);
        expGS(k == 10, k != 10, $sformatf("R9 activate after auto at +%0d", k));
      end else begin
        idle(k == 5);
      end
      check(a == (k == 8), $sformatf("R8 auto start at +%0d", k), a, k == 8);
    end
  endtask

  task automatic t_r11;
    tWr = 8'd0; tRp = 8'd0; tRas = 8'd0;
    doReset;
    req(ACT, 1'b0);
    req(WR, 1'b0);
    idle(1'b1);
    req(PRE, 1'b0);
    expGS(1'b1, 1'b0, "R11 zero counts precharge");
    req(ACT, 1'b0);
    expGS(1'b1, 1'b0, "R11 zero counts activate");
    tWr = 8'd3; tRp = 8'd2; tRas = 8'd5;
  endtask

  initial begin
    t_r1;
    t_r2_r10;
    t_r3_r9;
    t_r4;
    t_r5;
    t_r6;
    t_r7;
    t_r8;
    t_r11;
    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule